// File: doc/BRIEF.md
# ARINC 429 Word Mover over SPI

This block is the host-facing serial front end of an avionics data-bus controller. The host runs SPI mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge). Each transaction opens with one command byte, and the command byte decides what the data bytes that follow mean. The block moves 32-bit ARINC 429 words between the serial link and the logic around it. It can push a word into the transmit queue, pop a word from one of the receive queues, return the 24 high bits of a priority-label register, or load one receiver's set of three match labels.

The serial pins are brought into the system clock domain through synchronizers. Both SCLK edges are detected in that domain, so SCLK must stay well below the system clock rate. The queues, the priority registers and the per-receiver flip control belong to neighbouring logic. The block sees them only as plain word, flag and pulse ports. The match labels are held here and driven out to the label comparators.

Top module: `arinc_spi_bridge`

## Requirements
- R1: While chip select is high, MISO is 0 and the bit counter is cleared, so the next transaction starts again with a command byte. A rising SCLK edge that is seen in the same system cycle as chip-select release is discarded.
- R2: Command 0x0C takes four data bytes. Sent MSB first, they form the word bits 31..0 in order. `txq_push` pulses for one cycle, with that word on `txq_word`, only after the 32nd data bit. A shorter transaction pushes nothing.
- R3: Command 0xA0 + 0x20·n reads receive queue n. The bytes returned are word[31:24], word[23:16], word[15:8], then the label byte word[7:0]. Each byte is sent MSB first. Ports carry queue n in bits [32n+31:32n].
- R4: When `rx_flip[n]` is 1, the label byte of a queue-n read is sent with its bit order reversed. The first three bytes are not affected.
- R5: A queue read pulses `rxq_pop[n]` once, and only after all 32 data bits have been clocked. A read that is cut short does not pop. A read of an empty queue returns zeros and does not pop.
- R6: Command 0xA0 + 0x20·n + 4·k (k = 1..3) returns priority register k of receiver n as three bytes, bits 23..0 MSB first, with no label byte. The register sits at bits [24(3n+k-1)+23 : 24(3n+k-1)] of `prio_word`.
- R7: Command 0x14 + 0x18·n takes three label bytes in the order label 3, label 2, label 1. After the third byte, `match_lbl` bits [24n+23:24n] hold {label 3, label 2, label 1}. `rx_flip` has no effect on the stored labels. Fewer than three bytes leave the labels unchanged.
- R8: Write data bytes beyond the expected count are ignored. Read bytes beyond the defined count are returned as zero.
- R9: Any other command byte changes no output register and returns zeros for every data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rx_flip | input | NRX | Per-receiver label reversal enable |
| txq_push | output | 1 | One-cycle transmit queue write strobe |
| txq_word | output | WORD_W | Word written to the transmit queue |
| rxq_word | input | NRX·WORD_W | Head word of each receive queue |
| rxq_empty | input | NRX | Receive queue empty flags |
| rxq_pop | output | NRX | One-cycle receive queue pop strobes |
| prio_word | input | NRX·3·(WORD_W-8) | Priority-label register contents |
| match_lbl | output | NRX·3·8 | Stored match labels per receiver |

## Verification
The collision that matters is a rising SCLK edge that arrives in the same system cycle as chip-select release. That edge would complete the last bit of a word and fire a queue push, while the release clears the counter. The bench provokes it by raising SCLK and releasing chip select on the same system-clock edge, so both synchronizers present the two events together. It then checks that no push was counted, and that a full write issued right after still pushes exactly one correct word. The other checks sweep every command byte and compare the first returned byte, and the absence of side effects, against an arithmetic model of the command map.

// File: rtl/arinc_spi_pkg.sv
package arinc_spi_pkg;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_TXWR,
        OPK_RXRD,
        OPK_PRRD,
        OPK_MWR
    } op_kind_e;

    localparam int OCTET = 8;

    function automatic logic [OCTET-1:0] rev_octet(input logic [OCTET-1:0] b);
        logic [OCTET-1:0] r;
        for (int i = 0; i < OCTET; i++) begin
            r[i] = b[OCTET-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/arinc_spi_sync.sv
module arinc_spi_sync #(
    parameter int             N_BITS  = 3,
    parameter int             STAGES  = 2,
    parameter logic [N_BITS-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] din,
    output logic [N_BITS-1:0] dout
);

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[i]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[i]};
            end
        end

        assign dout[i] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/arinc_spi_opdec.sv
module arinc_spi_opdec
    import arinc_spi_pkg::*;
#(
    parameter int NRX = 2,
    localparam int RXW = (NRX > 1) ? $clog2(NRX) : 1
) (
    input  logic [7:0]     op,
    output op_kind_e       kind,
    output logic [RXW-1:0] rx_idx,
    output logic [1:0]     prio_sel
);

    always_comb begin
        kind     = OPK_NONE;
        rx_idx   = '0;
        prio_sel = 2'd0;
        if (op == 8'h0C) begin
            kind = OPK_TXWR;
        end
        for (int r = 0; r < NRX; r++) begin
            if (op[7:5] == 3'(5 + r) && !op[4] && op[1:0] == 2'b00) begin
                kind     = (op[3:2] == 2'd0) ? OPK_RXRD : OPK_PRRD;
                rx_idx   = RXW'(r);
                prio_sel = op[3:2];
            end
            if (op == 8'(8'h14 + r * 8'h18)) begin
                kind   = OPK_MWR;
                rx_idx = RXW'(r);
            end
        end
    end

endmodule

// File: rtl/arinc_spi_bridge.sv
module arinc_spi_bridge
    import arinc_spi_pkg::*;
#(
    parameter int NRX         = 2,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             spi_cs_n,
    input  logic                             spi_sclk,
    input  logic                             spi_mosi,
    output logic                             spi_miso,
    input  logic [NRX-1:0]                   rx_flip,
    output logic                             txq_push,
    output logic [WORD_W-1:0]                txq_word,
    input  logic [NRX*WORD_W-1:0]            rxq_word,
    input  logic [NRX-1:0]                   rxq_empty,
    output logic [NRX-1:0]                   rxq_pop,
    input  logic [NRX*3*(WORD_W-8)-1:0]      prio_word,
    output logic [NRX*3*8-1:0]               match_lbl
);

    localparam int LW    = OCTET;
    localparam int NPRIO = 3;
    localparam int PW    = WORD_W - LW;
    localparam int MW    = NPRIO * LW;
    localparam int OPB   = LW;
    localparam int CW    = $clog2(OPB + WORD_W + 1);
    localparam int RXW   = (NRX > 1) ? $clog2(NRX) : 1;
    localparam logic [CW-1:0] CNT_MAX  = {CW{1'b1}};
    localparam logic [CW-1:0] CNT_OP   = CW'(OPB - 1);
    localparam logic [CW-1:0] CNT_WORD = CW'(OPB + WORD_W - 1);
    localparam logic [CW-1:0] CNT_MTCH = CW'(OPB + MW - 1);

    typedef struct packed {
        logic [CW-1:0]            cnt;
        op_kind_e                 kind;
        logic [RXW-1:0]           rx;
        logic                     has_data;
        logic [WORD_W-1:0]        acc;
        logic [WORD_W-1:0]        out_sr;
        logic                     miso;
        logic                     sclk_prev;
        logic                     push;
        logic [WORD_W-1:0]        txw;
        logic [NRX-1:0]           pop;
        logic [NRX-1:0][MW-1:0]   match;
    } state_t;

    state_t st_d, st_q;

    logic [2:0] pins_s;
    logic       cs_s, sclk_s, mosi_s;
    logic       sclk_rise, sclk_fall;

    arinc_spi_sync #(
        .N_BITS  (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout  (pins_s)
    );

    assign cs_s      = pins_s[2];
    assign sclk_s    = pins_s[1];
    assign mosi_s    = pins_s[0];
    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign sclk_fall = ~sclk_s & st_q.sclk_prev;

    logic [LW-1:0]  op_byte;
    op_kind_e       dec_kind;
    logic [RXW-1:0] dec_rx;
    logic [1:0]     dec_prio;

    assign op_byte = {st_q.acc[LW-2:0], mosi_s};

    arinc_spi_opdec #(
        .NRX (NRX)
    ) u_dec (
        .op       (op_byte),
        .kind     (dec_kind),
        .rx_idx   (dec_rx),
        .prio_sel (dec_prio)
    );

    always_comb begin
        logic [WORD_W-1:0] rw;
        logic [PW-1:0]     pw;
        int                pidx;

        st_d           = st_q;
        st_d.push      = 1'b0;
        st_d.pop       = '0;
        st_d.sclk_prev = sclk_s;
        rw             = rxq_word[int'(dec_rx)*WORD_W +: WORD_W];
        pidx           = int'(dec_rx) * NPRIO + int'(dec_prio) - 1;
        if (pidx < 0) begin
            pidx = 0;
        end
        pw             = prio_word[pidx*PW +: PW];

        if (cs_s) begin
            st_d.cnt      = '0;
            st_d.kind     = OPK_NONE;
            st_d.has_data = 1'b0;
            st_d.out_sr   = '0;
            st_d.miso     = 1'b0;
        end else begin
            if (sclk_rise) begin
                st_d.cnt = (st_q.cnt == CNT_MAX) ? st_q.cnt : st_q.cnt + 1'b1;
                st_d.acc = {st_q.acc[WORD_W-2:0], mosi_s};

                if (st_q.cnt == CNT_OP) begin
                    st_d.kind     = dec_kind;
                    st_d.rx       = dec_rx;
                    st_d.has_data = 1'b0;
                    st_d.out_sr   = '0;
                    if (dec_kind == OPK_RXRD && !rxq_empty[dec_rx]) begin
                        st_d.has_data = 1'b1;
                        st_d.out_sr   = {rw[WORD_W-1:LW],
                                         rx_flip[dec_rx] ? rev_octet(rw[LW-1:0])
                                                         : rw[LW-1:0]};
                    end
                    if (dec_kind == OPK_PRRD) begin
                        st_d.out_sr = {pw, {LW{1'b0}}};
                    end
                end

                if (st_q.kind == OPK_TXWR && st_q.cnt == CNT_WORD) begin
                    st_d.push = 1'b1;
                    st_d.txw  = st_d.acc;
                end

                if (st_q.kind == OPK_MWR && st_q.cnt == CNT_MTCH) begin
                    st_d.match[st_q.rx] = st_d.acc[MW-1:0];
                end

                if (st_q.kind == OPK_RXRD && st_q.has_data && st_q.cnt == CNT_WORD) begin
                    st_d.pop[st_q.rx] = 1'b1;
                end
            end

            if (sclk_fall) begin
                st_d.miso   = st_q.out_sr[WORD_W-1];
                st_d.out_sr = {st_q.out_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.kind      <= OPK_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_miso  = st_q.miso;
    assign txq_push  = st_q.push;
    assign txq_word  = st_q.txw;
    assign rxq_pop   = st_q.pop;
    assign match_lbl = st_q.match;

    AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_miso); // R1

    AST_PUSH_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        txq_push |-> !$past(cs_s)); // R2

    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        txq_push |=> !txq_push); // R2

    AST_POP_ONE_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rxq_pop)); // R5

    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rxq_pop) |=> !(|rxq_pop)); // R5

    AST_MATCH_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(match_lbl)); // R7

endmodule

// File: tb/sim_arinc_spi_bridge.sv
module sim_arinc_spi_bridge;

    localparam int NRX = 2;
    localparam int WW  = 32;
    localparam int PW  = WW - 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sclk = 1'b0, spi_mosi = 1'b0;
    logic spi_miso;
    logic [NRX-1:0] rx_flip = '0;
    logic txq_push;
    logic [WW-1:0] txq_word;
    logic [NRX*WW-1:0] rxq_word;
    logic [NRX-1:0] rxq_empty = '0;
    logic [NRX-1:0] rxq_pop;
    logic [NRX*3*PW-1:0] prio_word;
    logic [NRX*24-1:0] match_lbl;

    always #5 clk = ~clk;

    arinc_spi_bridge #(.NRX(NRX), .WORD_W(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rx_flip(rx_flip),
        .txq_push(txq_push), .txq_word(txq_word), .rxq_word(rxq_word),
        .rxq_empty(rxq_empty), .rxq_pop(rxq_pop), .prio_word(prio_word),
        .match_lbl(match_lbl)
    );

    int checks = 0;
    int errors = 0;
    int push_cnt = 0;
    int pop_cnt [NRX];
    logic [WW-1:0] last_tx = '0;
    logic [7:0] txb [0:7];
    logic [7:0] rxb [0:7];

    function automatic logic [WW-1:0] qword(input int r);
        return 32'(32'hC3A5_5A81 + r * 32'h2979_D2CB);
    endfunction

    function automatic logic [PW-1:0] pval(input int r, input int k);
        return 24'((r * 3 + k) * 24'h1A2B37 + 24'h0F0F11);
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = b[7-i];
        return o;
    endfunction

    initial begin
        for (int r = 0; r < NRX; r++) begin
            rxq_word[r*WW +: WW] = qword(r);
            for (int k = 1; k <= 3; k++) begin
                prio_word[(r*3+k-1)*PW +: PW] = pval(r, k);
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (txq_push) begin
                push_cnt = push_cnt + 1;
                last_tx  = txq_word;
            end
            for (int r = 0; r < NRX; r++) begin
                if (rxq_pop[r]) pop_cnt[r] = pop_cnt[r] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input int nbytes, input bit cut_last);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int j = 0; j < nbytes; j++) begin
            for (int b = 7; b >= 0; b--) begin
                spi_mosi = txb[j][b];
                repeat (HALF) @(negedge clk);
                rxb[j][b] = spi_miso;
                spi_sclk = 1'b1;
                if (cut_last && j == nbytes - 1 && b == 0) spi_cs_n = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic clear_tx;
        for (int j = 0; j < 8; j++) txb[j] = 8'h00;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int p0, q0, q1;
        logic [WW-1:0] w;
        logic [NRX*24-1:0] m0;
        for (int r = 0; r < NRX; r++) pop_cnt[r] = 0;
        clear_tx();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(spi_miso == 1'b0 && txq_push == 1'b0 && rxq_pop == '0 && match_lbl == '0,
            "R1 reset", {spi_miso, txq_push, rxq_pop}, 0);

        // R9/R3/R6 sweep of every command byte, one data byte
        for (int op = 0; op < 256; op++) begin
            logic [7:0] exp;
            logic [7:0] o;
            o = 8'(op);
            exp = 8'h00;
            if ((o[7:5] == 3'd5 || o[7:5] == 3'd6) && !o[4] && o[1:0] == 2'b00) begin
                if (o[3:2] == 2'd0) exp = qword(int'(o[7:5]) - 5) >> 24;
                else exp = pval(int'(o[7:5]) - 5, int'(o[3:2])) >> 16;
            end
            p0 = push_cnt; q0 = pop_cnt[0]; q1 = pop_cnt[1]; m0 = match_lbl;
            clear_tx();
            txb[0] = o;
            xfer(2, 1'b0);
            chk(rxb[0] == 8'h00 && rxb[1] == exp && push_cnt == p0 && pop_cnt[0] == q0
                && pop_cnt[1] == q1 && match_lbl == m0,
                "R9 command sweep", {o, rxb[1]}, {o, exp});
        end

        // R2 transmit writes, several patterns
        for (int i = 0; i < 4; i++) begin
            w = 32'((i + 1) * 32'h9E37_79B9) ^ 32'(i * 32'h0101_0101);
            txb[0] = 8'h0C; txb[1] = w[31:24]; txb[2] = w[23:16];
            txb[3] = w[15:8]; txb[4] = w[7:0];
            p0 = push_cnt;
            xfer(5, 1'b0);
            chk(push_cnt == p0 + 1 && last_tx == w, "R2 tx write", last_tx, w);
        end

        // R8 extra write bytes ignored
        w = 32'h8123_4567;
        txb[0] = 8'h0C; txb[1] = 8'h81; txb[2] = 8'h23; txb[3] = 8'h45;
        txb[4] = 8'h67; txb[5] = 8'hFF; txb[6] = 8'hAA;
        p0 = push_cnt;
        xfer(7, 1'b0);
        chk(push_cnt == p0 + 1 && last_tx == w, "R8 extra tx bytes", last_tx, w);

        // R2 short write pushes nothing
        p0 = push_cnt;
        xfer(4, 1'b0);
        chk(push_cnt == p0, "R2 short tx", 64'(push_cnt), 64'(p0));

        // R1 cs release together with last rising edge
        txb[0] = 8'h0C; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'h44;
        p0 = push_cnt;
        xfer(5, 1'b1);
        chk(push_cnt == p0, "R1 cs wins over edge", 64'(push_cnt), 64'(p0));
        xfer(5, 1'b0);
        chk(push_cnt == p0 + 1 && last_tx == 32'h1122_3344, "R1 next frame clean",
            last_tx, 32'h1122_3344);

        // R3/R4/R5/R8 queue reads, both flip settings
        for (int r = 0; r < NRX; r++) begin
            for (int f = 0; f < 2; f++) begin
                logic [7:0] lb;
                clear_tx();
                rx_flip = '0;
                rx_flip[r] = f[0];
                w = qword(r);
                lb = f[0] ? rev8(w[7:0]) : w[7:0];
                txb[0] = 8'(8'hA0 + r * 8'h20);
                q0 = pop_cnt[r];
                xfer(6, 1'b0);
                chk({rxb[1], rxb[2], rxb[3]} == w[31:8], "R3 queue read data",
                    {rxb[1], rxb[2], rxb[3]}, w[31:8]);
                chk(rxb[4] == lb, f[0] ? "R4 flipped label" : "R3 plain label", rxb[4], lb);
                chk(rxb[5] == 8'h00, "R8 read past word", rxb[5], 0);
                chk(pop_cnt[r] == q0 + 1, "R5 pop after word", 64'(pop_cnt[r]), 64'(q0 + 1));
            end
        end
        rx_flip = '0;

        // R5 partial read does not pop
        clear_tx();
        txb[0] = 8'hA0;
        q0 = pop_cnt[0];
        xfer(4, 1'b0);
        chk(pop_cnt[0] == q0, "R5 partial read", 64'(pop_cnt[0]), 64'(q0));

        // R5 empty read returns zero, no pop
        rxq_empty = 2'b10;
        txb[0] = 8'hC0;
        q1 = pop_cnt[1];
        xfer(5, 1'b0);
        chk({rxb[1], rxb[2], rxb[3], rxb[4]} == 32'h0 && pop_cnt[1] == q1, "R5 empty read",
            {rxb[1], rxb[2], rxb[3], rxb[4]}, 0);
        rxq_empty = '0;

        // R6 priority register reads
        for (int r = 0; r < NRX; r++) begin
            for (int k = 1; k <= 3; k++) begin
                clear_tx();
                txb[0] = 8'(8'hA0 + r * 8'h20 + k * 4);
                q0 = pop_cnt[0]; q1 = pop_cnt[1];
                xfer(6, 1'b0);
                chk({rxb[1], rxb[2], rxb[3]} == pval(r, k) && rxb[4] == 8'h0 && rxb[5] == 8'h0
                    && pop_cnt[0] == q0 && pop_cnt[1] == q1, "R6 priority read",
                    {rxb[1], rxb[2], rxb[3], rxb[4]}, {pval(r, k), 8'h00});
            end
        end

        // R7 match writes with flip set, extra byte R8
        rx_flip = '1;
        for (int r = 0; r < NRX; r++) begin
            logic [23:0] lbl;
            lbl = 24'(24'h3A5C71 + r * 24'h214263);
            m0 = match_lbl;
            txb[0] = 8'(8'h14 + r * 8'h18);
            txb[1] = lbl[23:16]; txb[2] = lbl[15:8]; txb[3] = lbl[7:0]; txb[4] = 8'hEE;
            xfer(5, 1'b0);
            m0[r*24 +: 24] = lbl;
            chk(match_lbl == m0, "R7 match write", match_lbl, m0);
        end
        rx_flip = '0;

        // R7 partial match write leaves labels
        m0 = match_lbl;
        txb[0] = 8'h2C; txb[1] = 8'h01; txb[2] = 8'h02;
        xfer(3, 1'b0);
        chk(match_lbl == m0, "R7 partial match", match_lbl, m0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule